// File: doc/BRIEF.md
# Conversion-Ready and Calibration Sequencer

This block paces the result flow of a sigma-delta converter. It does no filtering. It counts output-data-rate ticks that arrive from outside the block. From those ticks it decides when a fresh result may be loaded into the data register and when the active-low ready flag falls. Three inputs hold it idle or restart it:

- a filter-hold level,
- a setup-register write carrying mode and filter-select codes,
- a calibration-coefficient write.

A self-calibration mode keeps a busy flag high. When the calibration ends, the block asks the register file to clear the mode code.

The result path is a stub counter that increments once per capture, so every delivered value reveals how many captures took place. The result output behaves like a valid/ready stream: valid is the inverse of `drdy_n`, and ready is the read-done strobe. There is no back-pressure. A tick that arrives while a result is still unread overwrites that result, and `drdy_n` goes high for one cycle so that the next falling edge can be seen.

Top module: `sd_ready_seq`

## Requirements
- R1: After reset: `drdy_n` is 1, `capture`, `cal_busy` and `mode_clr` are 0, and `result` is 0. The held mode code resets to 00 and the held filter-select code resets to 01.
- R2: While `sync_hold` is 1, ticks are ignored, no capture occurs and `drdy_n` stays 1. After `sync_hold` falls, settling starts again from zero.
- R3: With mode 00, the third rate tick after settling starts raises `capture` in the next cycle. In the cycle after that, `drdy_n` is 0 and `result` holds the new value.
- R4: A `rd_done` pulse that does not coincide with a capture sets `drdy_n` to 1 from the next cycle.
- R5: With mode 01, `cal_busy` is 1 for the first 6 ticks and `drdy_n` stays 1. On the 6th tick, `cal_busy` drops and `mode_clr` pulses for exactly one cycle, and the held mode becomes 00. The first capture follows the 9th tick.
- R6: Once settled, every tick causes one capture in the next cycle. `drdy_n` is 1 during that capture cycle and 0 after it, even when the previous result was never read. `result` rises by exactly 1 per capture.
- R7: A setup write whose mode or filter-select code differs from the held code sets `drdy_n` to 1 and restarts the count from zero. A write of identical codes has no effect.
- R8: Outside calibration, `cal_wr` sets `drdy_n` to 1 and suppresses captures until 3 more ticks have passed. During calibration, `cal_wr` is ignored.
- R9: Mode codes 10 and 11 behave like mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| rate_tick | input | 1 | one-cycle output-data-rate tick |
| sync_hold | input | 1 | holds filter and modulator idle while 1 |
| setup_wr | input | 1 | setup register write strobe |
| setup_mode | input | 2 | mode code written (00 convert, 01 self-calibrate) |
| setup_fs | input | 2 | filter-select code written |
| cal_wr | input | 1 | calibration-coefficient write strobe |
| rd_done | input | 1 | data-register read finished (stream ready) |
| drdy_n | output | 1 | active-low result ready (stream valid inverted) |
| capture | output | 1 | one-cycle strobe that loads a new result |
| result | output | DATA_W | stub data register |
| cal_busy | output | 1 | self-calibration in progress |
| mode_clr | output | 1 | one-cycle request to clear the mode code |

## Verification
All inputs are registered once. Each result therefore arrives on a fixed schedule:

- `capture` appears in the cycle after the qualifying tick.
- `result` and the falling `drdy_n` appear one cycle after `capture`.
- `cal_busy`, `mode_clr` and restart effects show in the cycle after the strobe that causes them.

The bench queues each expected result value at the moment it issues the qualifying tick. A monitor pops the queue on each `capture` and compares `result` and `drdy_n` one cycle later. Any capture that arrives while the queue is empty counts as an error, and so does any entry left in the queue at the end. This catches captures that come a tick early, come a tick late, or are missing.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_CAL    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_e;

  localparam logic [1:0] MODE_CONVERT = 2'b00;
  localparam logic [1:0] MODE_SELFCAL = 2'b01;

endpackage

// File: rtl/sdseq_tick_counter.sv
module sdseq_tick_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);

  logic [CNT_W-1:0] count;

  assign last = enable && tick && (count == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear || last) begin
      count <= '0;
    end else if (enable && tick) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/sdseq_setup_shadow.sv
module sdseq_setup_shadow
  import sdseq_pkg::*;
#(
  parameter logic [1:0] FS_RESET = 2'b01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       setup_wr,
  input  logic [1:0] setup_mode,
  input  logic [1:0] setup_fs,
  input  logic       cal_done,
  output logic       cfg_change,
  output logic       start_cal
);

  logic [1:0] mode_q;
  logic [1:0] fs_q;
  logic [1:0] mode_d;

  assign cfg_change = setup_wr && ((setup_mode != mode_q) || (setup_fs != fs_q));
  assign start_cal  = cfg_change ? (setup_mode == MODE_SELFCAL) : (mode_q == MODE_SELFCAL);

  always_comb begin
    mode_d = setup_wr ? setup_mode : mode_q;
    if (cal_done) mode_d = MODE_CONVERT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_CONVERT;
      fs_q   <= FS_RESET;
    end else begin
      mode_q <= mode_d;
      if (setup_wr) fs_q <= setup_fs;
    end
  end

endmodule

// File: rtl/sdseq_result_stub.sv
module sdseq_result_stub #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data <= '0;
    else if (load) data <= data + 1'b1;
  end

endmodule

// File: rtl/sdseq_ctrl.sv
module sdseq_ctrl
  import sdseq_pkg::*;
#(
  parameter int SETTLE_TICKS = 3,
  parameter int TOTAL_TICKS  = 9,
  parameter int CNT_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_hold,
  input  logic             cfg_change,
  input  logic             start_cal,
  input  logic             rate_tick,
  input  logic             cal_wr,
  input  logic             rd_done,
  input  logic             cnt_last,
  output logic             cnt_clear,
  output logic             cnt_enable,
  output logic [CNT_W-1:0] cnt_limit,
  output logic             cal_done,
  output seq_state_e       state,
  output logic             fire,
  output logic             drdy_n,
  output logic             mode_clr
);

  localparam int CAL_TICKS = TOTAL_TICKS - SETTLE_TICKS;

  logic cal_wr_hit;

  assign cal_wr_hit = cal_wr && (state == ST_SETTLE || state == ST_RUN);
  assign cnt_enable = (state == ST_CAL) || (state == ST_SETTLE);
  assign cnt_limit  = (state == ST_CAL) ? CNT_W'(CAL_TICKS) : CNT_W'(SETTLE_TICKS);
  assign cnt_clear  = sync_hold || cfg_change || cal_wr_hit || (state == ST_HOLD);
  assign cal_done   = !sync_hold && !cfg_change && (state == ST_CAL) && cnt_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HOLD;
      fire     <= 1'b0;
      drdy_n   <= 1'b1;
      mode_clr <= 1'b0;
    end else begin
      fire     <= 1'b0;
      mode_clr <= 1'b0;
      if (sync_hold) begin
        state  <= ST_HOLD;
        drdy_n <= 1'b1;
      end else if (cfg_change) begin
        state  <= start_cal ? ST_CAL : ST_SETTLE;
        drdy_n <= 1'b1;
      end else if (state == ST_HOLD) begin
        state  <= start_cal ? ST_CAL : ST_SETTLE;
      end else if (cal_wr_hit) begin
        state  <= ST_SETTLE;
        drdy_n <= 1'b1;
      end else begin
        if (fire)         drdy_n <= 1'b0;
        else if (rd_done) drdy_n <= 1'b1;
        unique case (state)
          ST_CAL: begin
            if (cnt_last) begin
              state    <= ST_SETTLE;
              mode_clr <= 1'b1;
            end
          end
          ST_SETTLE: begin
            if (cnt_last) begin
              state  <= ST_RUN;
              fire   <= 1'b1;
              drdy_n <= 1'b1;
            end
          end
          ST_RUN: begin
            if (rate_tick) begin
              fire   <= 1'b1;
              drdy_n <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sd_ready_seq.sv
module sd_ready_seq
  import sdseq_pkg::*;
#(
  parameter int         DATA_W       = 16,
  parameter int         SETTLE_TICKS = 3,
  parameter int         TOTAL_TICKS  = 9,
  parameter logic [1:0] FS_RESET     = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_tick,
  input  logic              sync_hold,
  input  logic              setup_wr,
  input  logic [1:0]        setup_mode,
  input  logic [1:0]        setup_fs,
  input  logic              cal_wr,
  input  logic              rd_done,
  output logic              drdy_n,
  output logic              capture,
  output logic [DATA_W-1:0] result,
  output logic              cal_busy,
  output logic              mode_clr
);

  localparam int MAX_TICKS = (TOTAL_TICKS > SETTLE_TICKS) ? TOTAL_TICKS : SETTLE_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic             cfg_change;
  logic             start_cal;
  logic             cal_done;
  logic             cnt_clear;
  logic             cnt_enable;
  logic             cnt_last;
  logic [CNT_W-1:0] cnt_limit;
  logic             fire;
  seq_state_e       state;

  sdseq_setup_shadow #(.FS_RESET(FS_RESET)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .setup_wr   (setup_wr),
    .setup_mode (setup_mode),
    .setup_fs   (setup_fs),
    .cal_done   (cal_done),
    .cfg_change (cfg_change),
    .start_cal  (start_cal)
  );

  sdseq_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cnt_clear),
    .enable (cnt_enable),
    .tick   (rate_tick),
    .limit  (cnt_limit),
    .last   (cnt_last)
  );

  sdseq_ctrl #(
    .SETTLE_TICKS (SETTLE_TICKS),
    .TOTAL_TICKS  (TOTAL_TICKS),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_hold  (sync_hold),
    .cfg_change (cfg_change),
    .start_cal  (start_cal),
    .rate_tick  (rate_tick),
    .cal_wr     (cal_wr),
    .rd_done    (rd_done),
    .cnt_last   (cnt_last),
    .cnt_clear  (cnt_clear),
    .cnt_enable (cnt_enable),
    .cnt_limit  (cnt_limit),
    .cal_done   (cal_done),
    .state      (state),
    .fire       (fire),
    .drdy_n     (drdy_n),
    .mode_clr   (mode_clr)
  );

  sdseq_result_stub #(.DATA_W(DATA_W)) u_stub (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire),
    .data  (result)
  );

  assign capture  = fire;
  assign cal_busy = (state == ST_CAL);

endmodule

// File: rtl/sd_ready_seq_chk.sv
module sd_ready_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_hold,
  input logic              rd_done,
  input logic              drdy_n,
  input logic              capture,
  input logic [DATA_W-1:0] result,
  input logic              cal_busy,
  input logic              mode_clr
);

  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hold |=> !capture); // R2

  AST_DRDY_FALL_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> $past(capture)); // R3

  AST_READ_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !capture) |=> drdy_n); // R4

  AST_CAL_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> drdy_n); // R5

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clr |=> !mode_clr); // R5

  AST_CLR_ENDS_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_clr) |-> $past(cal_busy) && !cal_busy); // R5

  AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture); // R6

  AST_RESULT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (result == $past(result) + 1'b1)); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(result)); // R6

endmodule

bind sd_ready_seq sd_ready_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_hold (sync_hold),
  .rd_done   (rd_done),
  .drdy_n    (drdy_n),
  .capture   (capture),
  .result    (result),
  .cal_busy  (cal_busy),
  .mode_clr  (mode_clr)
);

// File: tb/tb_sd_ready_seq.sv
module tb_sd_ready_seq;

  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rate_tick = 1'b0;
  logic              sync_hold = 1'b1;
  logic              setup_wr = 1'b0;
  logic [1:0]        setup_mode = 2'b00;
  logic [1:0]        setup_fs = 2'b01;
  logic              cal_wr = 1'b0;
  logic              rd_done = 1'b0;
  logic              drdy_n;
  logic              capture;
  logic [DATA_W-1:0] result;
  logic              cal_busy;
  logic              mode_clr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_val = 0;
  int exp_q[$];
  bit pend = 1'b0;
  int pend_val = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sd_ready_seq #(.DATA_W(DATA_W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_tick  (rate_tick),
    .sync_hold  (sync_hold),
    .setup_wr   (setup_wr),
    .setup_mode (setup_mode),
    .setup_fs   (setup_fs),
    .cal_wr     (cal_wr),
    .rd_done    (rd_done),
    .drdy_n     (drdy_n),
    .capture    (capture),
    .result     (result),
    .cal_busy   (cal_busy),
    .mode_clr   (mode_clr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // driver: one tick; when a capture is due, push its expected value
  task automatic pulse_tick(input bit expect_cap);
    @(negedge clk);
    if (expect_cap) begin
      exp_val++;
      exp_q.push_back(exp_val);
    end
    rate_tick = 1'b1;
    @(negedge clk);
    rate_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_setup(input logic [1:0] m, input logic [1:0] f);
    @(negedge clk);
    setup_wr = 1'b1; setup_mode = m; setup_fs = f;
    @(negedge clk);
    setup_wr = 1'b0;
  endtask

  task automatic strobe_cal_wr();
    @(negedge clk); cal_wr = 1'b1;
    @(negedge clk); cal_wr = 1'b0;
  endtask

  task automatic strobe_read();
    @(negedge clk); rd_done = 1'b1;
    @(negedge clk); rd_done = 1'b0;
  endtask

  // monitor: scoreboard pop on capture, compare one cycle later
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        check(result == DATA_W'(pend_val), "R6", "result after capture", int'(result), pend_val);
        check(drdy_n == 1'b0, "R3", "drdy_n after capture", int'(drdy_n), 0);
        pend = 1'b0;
      end
      if (capture) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected capture", 1, 0);
        end else begin
          pend_val = exp_q.pop_front();
          pend = 1'b1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      check(1'b0, "ALL", "watchdog expired", cyc, 20000);
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(drdy_n == 1'b1, "R1", "drdy_n at reset", int'(drdy_n), 1);
    check(capture == 1'b0, "R1", "capture at reset", int'(capture), 0);
    check(cal_busy == 1'b0, "R1", "cal_busy at reset", int'(cal_busy), 0);
    check(mode_clr == 1'b0, "R1", "mode_clr at reset", int'(mode_clr), 0);
    check(result == '0, "R1", "result at reset", int'(result), 0);

    // R2 ticks while held do nothing
    for (int i = 0; i < 4; i++) pulse_tick(1'b0);
    check(drdy_n == 1'b1, "R2", "drdy_n while held", int'(drdy_n), 1);

    // R3 normal settling: third tick
    @(negedge clk); sync_hold = 1'b0;
    idle(2);
    pulse_tick(1'b0);
    pulse_tick(1'b0);
    check(drdy_n == 1'b1, "R3", "drdy_n before 3rd tick", int'(drdy_n), 1);
    pulse_tick(1'b1);
    check(capture == 1'b1, "R3", "capture after 3rd tick", int'(capture), 1);
    idle(2);

    // R4 read raises drdy_n
    strobe_read();
    check(drdy_n == 1'b1, "R4", "drdy_n after read", int'(drdy_n), 1);

    // R6 each tick captures; unread result overwritten with high pulse
    pulse_tick(1'b1);
    idle(2);
    pulse_tick(1'b1);
    check(drdy_n == 1'b1, "R6", "drdy_n high in capture cycle", int'(drdy_n), 1);
    idle(2);

    // R7 identical write (held fs resets to 01, mode 00) has no effect
    write_setup(2'b00, 2'b01);
    check(drdy_n == 1'b0, "R7", "drdy_n after identical setup", int'(drdy_n), 0);
    pulse_tick(1'b1);
    idle(2);

    // R7 changed filter code restarts settling
    write_setup(2'b00, 2'b10);
    check(drdy_n == 1'b1, "R7", "drdy_n after changed setup", int'(drdy_n), 1);
    pulse_tick(1'b0);
    pulse_tick(1'b0);
    pulse_tick(1'b1);
    idle(2);

    // R8 calibration write discards and resettles
    strobe_cal_wr();
    check(drdy_n == 1'b1, "R8", "drdy_n after cal write", int'(drdy_n), 1);
    pulse_tick(1'b0);
    pulse_tick(1'b0);
    pulse_tick(1'b1);
    idle(2);

    // R5 self-calibration
    write_setup(2'b01, 2'b10);
    check(cal_busy == 1'b1, "R5", "cal_busy at start", int'(cal_busy), 1);
    check(drdy_n == 1'b1, "R5", "drdy_n at cal start", int'(drdy_n), 1);
    for (int i = 0; i < 5; i++) pulse_tick(1'b0);
    strobe_cal_wr();
    check(cal_busy == 1'b1, "R8", "cal write ignored in cal", int'(cal_busy), 1);
    pulse_tick(1'b0);
    check(mode_clr == 1'b1, "R5", "mode_clr after 6th tick", int'(mode_clr), 1);
    check(cal_busy == 1'b0, "R5", "cal_busy after 6th tick", int'(cal_busy), 0);
    @(negedge clk);
    check(mode_clr == 1'b0, "R5", "mode_clr single cycle", int'(mode_clr), 0);
    pulse_tick(1'b0);
    pulse_tick(1'b0);
    check(drdy_n == 1'b1, "R5", "drdy_n before 9th tick", int'(drdy_n), 1);
    pulse_tick(1'b1);
    idle(2);

    // R5 held mode cleared: writing 00 with same fs is no change
    write_setup(2'b00, 2'b10);
    check(drdy_n == 1'b0, "R5", "held mode cleared to 00", int'(drdy_n), 0);
    pulse_tick(1'b1);
    idle(2);

    // R9 mode 10 behaves as normal conversion
    write_setup(2'b10, 2'b10);
    check(cal_busy == 1'b0, "R9", "mode 10 not calibrating", int'(cal_busy), 0);
    pulse_tick(1'b0);
    pulse_tick(1'b0);
    pulse_tick(1'b1);
    idle(2);

    // R2 hold mid-run, then settling restarts
    @(negedge clk); sync_hold = 1'b1;
    @(negedge clk);
    check(drdy_n == 1'b1, "R2", "drdy_n after hold", int'(drdy_n), 1);
    pulse_tick(1'b0);
    @(negedge clk); sync_hold = 1'b0;
    idle(2);
    pulse_tick(1'b0);
    pulse_tick(1'b0);
    pulse_tick(1'b1);
    idle(4);

    check(exp_q.size() == 0, "R6", "expected captures left", exp_q.size(), 0);
    check(result == DATA_W'(exp_val), "R6", "final result", int'(result), exp_val);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule